// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block models a synchronous static memory with a built-in four-beat burst sequencer, sized by parameters so that a small array can be checked against a reference model. Each rising clock edge is decoded into one of five operations: no operation, deselect, begin read, begin write, or burst continuation. The decode uses a three-input chip enable group, two address strobes with different rules, an advance input and a global/byte write group. The 18-bit word is split into two 9-bit lanes, and each lane can be written on its own.

The address strobes work differently. The processor strobe can only start a read, and the master enable gates it. The controller strobe is not gated by the master enable, but it only counts when the processor strobe is not in effect. On a controller-strobe edge, the write inputs decide whether the new cycle is a read or a write. After a cycle has begun, edges with no strobe continue it. A continuation edge with advance low steps the burst counter. A continuation edge with advance high stays on the current address. A continuation edge with a lane write asserted writes that lane.

Read data leaves through a registered pipeline stage by default. A mode input selects a flow-through path, in which data appears in the same cycle from the single address register. The output enable is asynchronous. A sleep input freezes the block. The data port has no back-pressure: the memory accepts one operation on every edge, and the output enable flag marks valid read data.

Top module: `sram_burst_core`

## Requirements
- R1: The controller strobe (`ctl_stb_n_i` low) starts a cycle only when the processor strobe is not in effect on the same edge. If both strobes are low and the master enable is active, the cycle is a processor-strobe read, and no write happens.
- R2: When `en_main_n_i` is high, a low processor strobe is ignored. With the controller strobe high, the edge is then a burst continuation, and the new address is not loaded.
- R3: An edge with an effective strobe is a deselect unless `en_main_n_i`=0, `en_hi_i`=1 and `en_lo_n_i`=0. A deselect ends the burst. In pipelined mode the bus is still driven for the cycle after the deselect edge, and it is undriven after the following edge.
- R4: Lane write decode works as follows. If `gw_n_i` is low, both lanes are written. Otherwise, if `bwe_n_i` is low, each low bit of `lane_we_n_i` writes its lane: bit 0 writes data bits 8:0 and bit 1 writes bits 17:9. With no lane selected, or with `bwe_n_i` high, the edge is a read.
- R5: An edge that starts a cycle with the processor strobe is always a read, whatever the write inputs are. A following continuation edge with a lane write and advance high writes the same address.
- R6: A controller-strobe start samples the write inputs and `din_i` on that same edge, and writes to `addr_i`.
- R7: In pipelined mode (`flow_n_i`=1), the word for an address registered on edge k appears on `dout_o` after edge k+1.
- R8: In flow-through mode (`flow_n_i`=0), the word for an address registered on edge k appears on `dout_o` after edge k.
- R9: `dout_oe_o` is 1 only while `oe_n_i` is low and the block is in read mode, and it follows `oe_n_i` without waiting for a clock. After any edge that writes, the bus is undriven, even with `oe_n_i` low. When undriven, `dout_o` is zero.
- R10: A continuation edge with `adv_n_i` low steps a 2-bit beat count. With `interleave_i`=1, the low two address bits are the start bits XOR the count. The upper bits never change. With `adv_n_i` high, the address holds.
- R11: With `interleave_i`=0, the low two address bits are the start bits plus the count, modulo 4.
- R12: While `sleep_i` is high, every command is ignored. Burst state and array contents are kept, and the bus is undriven.
- R13: While `rst_n` is low, and after it is released, the bus is undriven and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, loaded on a start edge |
| en_main_n_i | input | 1 | Master chip enable, active low; gates the processor strobe |
| en_hi_i | input | 1 | Second chip enable, active high |
| en_lo_n_i | input | 1 | Third chip enable, active low |
| cpu_stb_n_i | input | 1 | Processor address strobe, active low |
| ctl_stb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write of all lanes, active low |
| bwe_n_i | input | 1 | Lane write qualifier, active low |
| lane_we_n_i | input | LANES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Low-power hold, active high |
| flow_n_i | input | 1 | 0 selects flow-through reads, 1 selects pipelined reads |
| interleave_i | input | 1 | 1 selects interleaved burst order, 0 selects linear order |
| din_i | input | LANES*LANE_W | Write data |
| dout_o | output | LANES*LANE_W | Read data, zero while undriven |
| dout_oe_o | output | 1 | Bus drive enable |

## Verification
If the beat counter or the start address is wrong, the wrong stored word shows on `dout_o`. In pipelined mode this appears one edge after the bad address was registered; in flow-through mode it appears in the same cycle. A read-mode flag that is left set after a write, deselect or sleep edge shows as `dout_oe_o` being high one cycle too long. A wrong lane decode cannot be seen at once. It only shows when the word is read back, which is why every write in the stimulus is followed by a read of the same address.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  localparam int BURST_BITS = 2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DESEL,
    OP_START_RD,
    OP_START_WR,
    OP_CONT
  } sram_op_e;

  // Low address bits of a burst beat: XOR order or modulo-4 add order.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] start_bits,
    input logic [BURST_BITS-1:0] beat,
    input logic                  interleave
  );
    return interleave ? (start_bits ^ beat) : (start_bits + beat);
  endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_burst_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             en_main_n,
  input  logic             en_hi,
  input  logic             en_lo_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             sleep,
  input  logic             active,
  output sram_op_e         op,
  output logic [LANES-1:0] lane_wr,
  output logic             step
);

  logic             cpu_go;
  logic             ctl_go;
  logic             en_ok;
  logic [LANES-1:0] lane_req;

  // R2: the master enable gates the processor strobe only.
  assign cpu_go = !cpu_stb_n && !en_main_n;
  // R1: the controller strobe counts only if the processor strobe is not in effect.
  assign ctl_go = !ctl_stb_n && !cpu_go;
  assign en_ok  = !en_main_n && en_hi && !en_lo_n;

  always_comb begin
    // R4: global write beats lane selects; lanes need the qualifier.
    lane_req = '0;
    if (!gw_n)       lane_req = '1;
    else if (!bwe_n) lane_req = ~lane_we_n;

    op      = OP_NONE;
    lane_wr = '0;
    step    = 1'b0;
    if (!sleep) begin
      if (cpu_go || ctl_go) begin
        if (!en_ok)                       op = OP_DESEL;      // R3
        else if (cpu_go || lane_req == '0) op = OP_START_RD;  // R5
        else begin
          op      = OP_START_WR;                              // R6
          lane_wr = lane_req;
        end
      end else if (active) begin
        op      = OP_CONT;
        lane_wr = lane_req;
        step    = !adv_n;
      end
    end
  end

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  sram_op_e          op,
  input  logic              step,
  input  logic              is_wr,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              rd_mode
);

  localparam int BB = BURST_BITS;

  logic [ADDR_W-1:0] base;
  logic [BB-1:0]     cnt;
  logic [BB-1:0]     cnt_nx;
  logic [BB-1:0]     low_now;
  logic [BB-1:0]     low_nx;
  logic              is_start;

  assign cnt_nx   = cnt + BB'(1);
  assign low_now  = burst_low(base[BB-1:0], cnt, interleave);
  assign low_nx   = burst_low(base[BB-1:0], cnt_nx, interleave);
  assign cur_addr = {base[ADDR_W-1:BB], low_now};
  assign is_start = (op == OP_START_RD) || (op == OP_START_WR);

  always_comb begin
    if (is_start)  acc_addr = addr_in;
    else if (step) acc_addr = {base[ADDR_W-1:BB], low_nx};
    else           acc_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      rd_mode <= 1'b0;
    end else if (!sleep) begin
      unique case (op)
        OP_DESEL: begin
          active  <= 1'b0;
          rd_mode <= 1'b0;
        end
        OP_START_RD, OP_START_WR: begin
          base    <= addr_in;
          cnt     <= '0;
          active  <= 1'b1;
          rd_mode <= (op == OP_START_RD);
        end
        OP_CONT: begin
          if (step) cnt <= cnt_nx;
          rd_mode <= !is_wr;
        end
        default: rd_mode <= 1'b0;
      endcase
    end
  end

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> ($stable(base) && $stable(cnt) && $stable(active)));  // R12
  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_DESEL) |=> (!active && !rd_mode));  // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_CONT && step) |=> (cnt == BB'($past(cnt) + BB'(1))));  // R10

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/sram_read_path.sv
module sram_read_path #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              flow_n,
  input  logic              oe_n,
  input  logic              rd_mode,
  input  logic              wr_now,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe
);

  logic              drv_q;
  logic [DATA_W-1:0] dat_q;
  logic              drv;
  logic [DATA_W-1:0] dat;

  // R7: one extra register stage in pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      dat_q <= '0;
    end else if (!sleep) begin
      drv_q <= rd_mode && !wr_now;
      dat_q <= rdata;
    end
  end

  // R8: flow-through takes the array output of the address register directly.
  assign drv   = flow_n ? drv_q : rd_mode;
  assign dat   = flow_n ? dat_q : rdata;
  assign dq_oe = !oe_n && !sleep && drv;   // R9
  assign dq    = dq_oe ? dat : '0;

endmodule

// File: rtl/sram_burst_core.sv
module sram_burst_core
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    en_main_n_i,
  input  logic                    en_hi_i,
  input  logic                    en_lo_n_i,
  input  logic                    cpu_stb_n_i,
  input  logic                    ctl_stb_n_i,
  input  logic                    adv_n_i,
  input  logic                    gw_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        lane_we_n_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  input  logic                    flow_n_i,
  input  logic                    interleave_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_oe_o
);

  localparam int DATA_W = LANES * LANE_W;

  sram_op_e          op;
  logic [LANES-1:0]  mem_we;
  logic              step;
  logic              active;
  logic              rd_mode;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rdata;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .en_main_n (en_main_n_i),
    .en_hi     (en_hi_i),
    .en_lo_n   (en_lo_n_i),
    .cpu_stb_n (cpu_stb_n_i),
    .ctl_stb_n (ctl_stb_n_i),
    .adv_n     (adv_n_i),
    .gw_n      (gw_n_i),
    .bwe_n     (bwe_n_i),
    .lane_we_n (lane_we_n_i),
    .sleep     (sleep_i),
    .active    (active),
    .op        (op),
    .lane_wr   (mem_we),
    .step      (step)
  );

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep_i),
    .op         (op),
    .step       (step),
    .is_wr      (|mem_we),
    .interleave (interleave_i),
    .addr_in    (addr_i),
    .acc_addr   (acc_addr),
    .cur_addr   (cur_addr),
    .active     (active),
    .rd_mode    (rd_mode)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (acc_addr),
    .wdata (din_i),
    .raddr (cur_addr),
    .rdata (rdata)
  );

  sram_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep_i),
    .flow_n  (flow_n_i),
    .oe_n    (oe_n_i),
    .rd_mode (rd_mode),
    .wr_now  (|mem_we),
    .rdata   (rdata),
    .dq      (dout_o),
    .dq_oe   (dout_oe_o)
  );

  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n) (!cpu_stb_n_i && !en_main_n_i) |-> (mem_we == '0));  // R5
  AST_WRITE_BLANKS_BUS: assert property (@(posedge clk) disable iff (!rst_n) (|mem_we) |=> !dout_oe_o);  // R9
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) sleep_i |-> (mem_we == '0));  // R12

endmodule

// File: tb/sram_burst_core_tb.sv
`timescale 1ns/1ps
module sram_burst_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        en_main_n, en_hi, en_lo_n, cpu_n, ctl_n, adv_n, gw_n, bwe_n;
  logic [1:0]  lane_n;
  logic        oe_n, sleep, flow_n, ilv;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_oe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sram_burst_core dut_i (
    .clk (clk), .rst_n (rst_n), .addr_i (addr),
    .en_main_n_i (en_main_n), .en_hi_i (en_hi), .en_lo_n_i (en_lo_n),
    .cpu_stb_n_i (cpu_n), .ctl_stb_n_i (ctl_n), .adv_n_i (adv_n),
    .gw_n_i (gw_n), .bwe_n_i (bwe_n), .lane_we_n_i (lane_n),
    .oe_n_i (oe_n), .sleep_i (sleep), .flow_n_i (flow_n), .interleave_i (ilv),
    .din_i (din), .dout_o (dout), .dout_oe_o (dout_oe)
  );

  // Control byte: {en_main_n, en_hi, en_lo_n, cpu_n, ctl_n, adv_n, gw_n, bwe_n}
  localparam logic [7:0] C_IDLE = 8'b01011111;
  localparam logic [7:0] C_CSW  = 8'b01010101;
  localparam logic [7:0] C_CSL  = 8'b01010110;
  localparam logic [7:0] C_CSR  = 8'b01010111;
  localparam logic [7:0] C_PSR  = 8'b01001101;
  localparam logic [7:0] C_BOTH = 8'b01000101;
  localparam logic [7:0] C_ADVR = 8'b01011011;
  localparam logic [7:0] C_ADVW = 8'b01011001;
  localparam logic [7:0] C_SUSL = 8'b01011110;
  localparam logic [7:0] C_DSEL = 8'b00010111;
  localparam logic [7:0] C_BLK  = 8'b11001011;

  // Vector: {req[3:0], ctl[7:0], lanes_n[1:0], addr[5:0], din[17:0], exp_oe, exp_dout[17:0]}
  localparam int NV = 32;
  localparam logic [56:0] VEC [NV] = '{
    {4'd6,  C_CSW,  2'b11, 6'd8,  18'h00A01, 1'b0, 18'h0},       // R6 write
    {4'd6,  C_CSW,  2'b11, 6'd9,  18'h00B02, 1'b0, 18'h0},       // R6
    {4'd6,  C_CSW,  2'b11, 6'd10, 18'h00C03, 1'b0, 18'h0},       // R6
    {4'd6,  C_CSW,  2'b11, 6'd11, 18'h00D04, 1'b0, 18'h0},       // R6
    {4'd1,  C_CSR,  2'b11, 6'd9,  18'h0,     1'b0, 18'h0},       // R1 read start
    {4'd7,  C_ADVR, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00B02},   // R7 one edge later
    {4'd10, C_ADVR, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00A01},   // R10 01^01
    {4'd10, C_ADVR, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00D04},   // R10 01^10
    {4'd10, C_IDLE, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00C03},   // R10 01^11, hold
    {4'd3,  C_DSEL, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00C03},   // R3 still driven
    {4'd3,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b0, 18'h0},       // R3 undriven
    {4'd5,  C_PSR,  2'b11, 6'd8,  18'h3FFFF, 1'b0, 18'h0},       // R5 read despite gw
    {4'd9,  C_SUSL, 2'b10, 6'd0,  18'h155AA, 1'b0, 18'h0},       // R9 write blanks, lane 0
    {4'd9,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b0, 18'h0},       // R9
    {4'd4,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00BAA},   // R4 lane 0 merged, R5
    {4'd4,  C_CSL,  2'b01, 6'd9,  18'h3FFFF, 1'b0, 18'h0},       // R4 lane 1 write
    {4'd4,  C_CSR,  2'b00, 6'd9,  18'h0,     1'b0, 18'h0},       // R4 lanes ignored
    {4'd4,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b1, 18'h3FF02},   // R4
    {4'd2,  C_BLK,  2'b11, 6'd40, 18'h0,     1'b1, 18'h3FF02},   // R2 blocked strobe
    {4'd2,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00BAA},   // R2 advanced, not 40
    {4'd1,  C_BOTH, 2'b11, 6'd11, 18'h0,     1'b1, 18'h00BAA},   // R1 both strobes
    {4'd1,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b1, 18'h00D04},   // R1 no write
    {4'd6,  C_CSW,  2'b11, 6'd12, 18'h01111, 1'b0, 18'h0},       // R6
    {4'd10, C_ADVW, 2'b11, 6'd0,  18'h02222, 1'b0, 18'h0},       // R10 write 13
    {4'd10, C_ADVW, 2'b11, 6'd0,  18'h03333, 1'b0, 18'h0},       // R10 write 14
    {4'd10, C_ADVW, 2'b11, 6'd0,  18'h04444, 1'b0, 18'h0},       // R10 write 15
    {4'd10, C_CSR,  2'b11, 6'd13, 18'h0,     1'b0, 18'h0},       // R10
    {4'd10, C_ADVR, 2'b11, 6'd0,  18'h0,     1'b1, 18'h02222},   // R10
    {4'd10, C_ADVR, 2'b11, 6'd0,  18'h0,     1'b1, 18'h01111},   // R10
    {4'd10, C_IDLE, 2'b11, 6'd0,  18'h0,     1'b1, 18'h04444},   // R10
    {4'd3,  C_DSEL, 2'b11, 6'd0,  18'h0,     1'b1, 18'h04444},   // R3
    {4'd3,  C_IDLE, 2'b11, 6'd0,  18'h0,     1'b0, 18'h0}        // R3
  };

  task automatic drive(input logic [7:0] c, input logic [1:0] ln,
                       input logic [5:0] a, input logic [17:0] d);
    {en_main_n, en_hi, en_lo_n, cpu_n, ctl_n, adv_n, gw_n, bwe_n} = c;
    lane_n = ln;
    addr   = a;
    din    = d;
  endtask

  task automatic step(input logic [7:0] c, input logic [1:0] ln,
                      input logic [5:0] a, input logic [17:0] d);
    drive(c, ln, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int r, input logic eo, input logic [17:0] ed);
    checks++;
    if (dout_oe !== eo || (eo && dout !== ed)) begin
      fails++;
      $display("FAIL R%0d: oe=%0b dout=%h expected oe=%0b dout=%h", r, dout_oe, dout, eo, ed);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL R13: watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; flow_n = 1'b1; ilv = 1'b1;
    drive(C_IDLE, 2'b11, 6'd0, 18'h0);
    @(negedge clk); @(negedge clk);
    chk(13, 1'b0, 18'h0);                       // R13 reset state
    rst_n = 1'b1;
    step(C_IDLE, 2'b11, 6'd0, 18'h0);
    chk(13, 1'b0, 18'h0);                       // R13 no burst after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][52:45], VEC[i][44:43], VEC[i][42:37], VEC[i][36:19]);
      chk(int'(VEC[i][56:53]), VEC[i][18], VEC[i][17:0]);
    end

    // R8 flow-through: data in the same cycle
    flow_n = 1'b0;
    step(C_CSR, 2'b11, 6'd9, 18'h0);
    chk(8, 1'b1, 18'h3FF02);                    // R8
    step(C_ADVR, 2'b11, 6'd0, 18'h0);
    chk(8, 1'b1, 18'h00BAA);                    // R8 beat 01^01
    // R9 asynchronous output enable
    oe_n = 1'b1; #1;
    chk(9, 1'b0, 18'h0);                        // R9
    oe_n = 1'b0; #1;
    chk(9, 1'b1, 18'h00BAA);                    // R9
    @(negedge clk);
    flow_n = 1'b1;

    // R11 linear order from start bits 10
    ilv = 1'b0;
    step(C_CSR, 2'b11, 6'd14, 18'h0);
    step(C_ADVR, 2'b11, 6'd0, 18'h0);
    chk(11, 1'b1, 18'h03333);                   // R11 addr 14
    step(C_ADVR, 2'b11, 6'd0, 18'h0);
    chk(11, 1'b1, 18'h04444);                   // R11 addr 15
    step(C_ADVR, 2'b11, 6'd0, 18'h0);
    chk(11, 1'b1, 18'h01111);                   // R11 wrap to 12
    step(C_IDLE, 2'b11, 6'd0, 18'h0);
    chk(11, 1'b1, 18'h02222);                   // R11 addr 13

    // R12 sleep ignores commands and keeps state
    sleep = 1'b1;
    step(C_CSW, 2'b11, 6'd14, 18'h0);
    chk(12, 1'b0, 18'h0);                       // R12 undriven
    step(C_ADVR, 2'b11, 6'd0, 18'h0);
    chk(12, 1'b0, 18'h0);                       // R12
    sleep = 1'b0;
    step(C_IDLE, 2'b11, 6'd0, 18'h0);
    chk(12, 1'b1, 18'h02222);                   // R12 address held at 13
    step(C_CSR, 2'b11, 6'd14, 18'h0);
    step(C_IDLE, 2'b11, 6'd0, 18'h0);
    chk(12, 1'b1, 18'h03333);                   // R12 contents kept

    // R13 reset during a read burst
    rst_n = 1'b0; #1;
    chk(13, 1'b0, 18'h0);                       // R13
    @(negedge clk);
    rst_n = 1'b1;
    step(C_IDLE, 2'b11, 6'd0, 18'h0);
    chk(13, 1'b0, 18'h0);                       // R13

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule